// File: doc/BRIEF.md
# Stacked CAM Chain Controller

This block sits beside the array of one content-addressable memory device and lets several such devices be stacked into one deeper memory with no glue logic between them. Each device holds a page number, written once at start-up, that becomes the upper bits of any address it reports. Each device also holds a target register. The device takes part in a cycle when the target equals its own page number, or when the target is all ones. The all-ones value reaches every device in the stack at once.

After each compare, the array's local results are captured: match, full and the best local address. Two active-low flags ripple from device to device, one for match and one for full. Each device merges its own captured result into the flag it passes downstream. From the incoming flags and its own state, a device works out whether it owns the system's highest-priority match, meaning no earlier device matched. It also works out whether it owns the next free slot, meaning every earlier device is full and this one is not. A cycle-type code then decides whether the device answers. Operations aimed at the best match or at the next free slot get exactly one answering device. Broadcast commands and data writes reach every selected device. Ordinary reads are refused by any device that found no match. The first device in the stack ties its match input high and its full input low.

Top module: `cam_chain_ctrl`

## Requirements
- R1: After reset the page register is zero, the target register is all ones and the captured match and full flags are clear. Neither ownership output is high, and `hit_addr` is zero.
- R2: A cycle with `page_we` high loads `page_wd` into the page register. While the device owns the match, `hit_addr` carries the page register in its upper PAGE_W bits and the captured local address in its lower ADDR_W bits.
- R3: The device is selected when the target register equals the page register, or when the target register is all ones. A cycle with `dsel_we` high loads `dsel_wd` into the target register.
- R4: A cycle with `cmp_load` high captures `loc_match`, `loc_full` and `loc_addr`. In any other cycle the captured values are held.
- R5: `match_out_n` is low exactly when `match_in_n` is low or the captured match is set.
- R6: `full_out_n` is low exactly when `full_in_n` is low and the captured full is set.
- R7: `hit_own` is high exactly when the captured match is set and `match_in_n` is high. `hit_addr` is zero whenever `hit_own` is low.
- R8: `free_own` is high exactly when `full_in_n` is low and the captured full is clear.
- R9: With `cyc_valid` high, cycle code 0 (broadcast command or data write) and cycle code 4 (read of the next-free register) set `resp` exactly when the device is selected. Code 4 is not blocked by a missing match.
- R10: With `cyc_valid` high, cycle code 1 (operation on the highest-match address) sets `resp` exactly when the device is selected and `hit_own` is high.
- R11: With `cyc_valid` high, cycle code 2 (operation on the next-free address) sets `resp` exactly when the device is selected and `free_own` is high.
- R12: With `cyc_valid` high, cycle code 3 (read of memory or of any other register) sets `resp` exactly when the device is selected and the captured match is set.
- R13: `resp` is low when `cyc_valid` is low, and for cycle codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| page_we | input | 1 | Write strobe for the page register |
| page_wd | input | PAGE_W | Page number to load |
| dsel_we | input | 1 | Write strobe for the target register |
| dsel_wd | input | PAGE_W | Target value to load; all ones means broadcast |
| cmp_load | input | 1 | Captures the array's compare results |
| loc_match | input | 1 | Array reports at least one local match |
| loc_full | input | 1 | Array reports no free location |
| loc_addr | input | ADDR_W | Array's highest-priority local match address |
| match_in_n | input | 1 | Active-low match flag from the previous device |
| full_in_n | input | 1 | Active-low all-full flag from the previous device |
| match_out_n | output | 1 | Active-low match flag to the next device |
| full_out_n | output | 1 | Active-low all-full flag to the next device |
| hit_own | output | 1 | This device holds the system's highest-priority match |
| free_own | output | 1 | This device holds the system's next free slot |
| hit_addr | output | PAGE_W+ADDR_W | System match address while `hit_own` is high, else zero |
| cyc_valid | input | 1 | A bus cycle is present |
| cyc_kind | input | 3 | Cycle code as listed in R9 to R13 |
| resp | output | 1 | This device answers the present cycle |

## Verification
Assertions check four things on every cycle. Captured results stay put unless a compare load occurs, and the page register takes the written value. The two ownership outputs always agree with the flags this device sends downstream. A response to a best-match or next-free cycle only ever comes from the owning device. The bench's sweep is the only place where all of these combinations are confirmed together: every local match and full state, every incoming flag pair and every cycle code, under targeted, broadcast and unselected targets. The same applies to reset values, how the upper bits of the reported address are formed, and the refusal of ordinary reads with no local match.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;

  typedef enum logic [2:0] {
    CYC_BCAST   = 3'd0,
    CYC_HIT     = 3'd1,
    CYC_FREE    = 3'd2,
    CYC_READ    = 3'd3,
    CYC_FREE_RD = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic match;
    logic full;
  } stat_flags_t;

endpackage

// File: rtl/chain_id_regs.sv
module chain_id_regs #(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wd,
  input  logic              dsel_we,
  input  logic [PAGE_W-1:0] dsel_wd,
  output logic [PAGE_W-1:0] page_q,
  output logic              selected
);

  localparam logic [PAGE_W-1:0] BCAST_ID = '1;

  logic [PAGE_W-1:0] page_d;
  logic [PAGE_W-1:0] dsel_q;
  logic [PAGE_W-1:0] dsel_d;

  always_comb begin
    page_d = page_q;
    dsel_d = dsel_q;
    if (page_we) page_d = page_wd;
    if (dsel_we) dsel_d = dsel_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      dsel_q <= BCAST_ID;
    end else begin
      page_q <= page_d;
      dsel_q <= dsel_d;
    end
  end

  always_comb begin
    selected = (dsel_q == page_q) || (dsel_q == BCAST_ID);
  end

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> (page_q == $past(page_wd)));

  // R3
  dsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsel_we && (dsel_wd == BCAST_ID)) |=> selected);

endmodule

// File: rtl/chain_flag_stage.sv
module chain_flag_stage
  import cam_chain_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_load,
  input  logic              loc_match,
  input  logic              loc_full,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              match_in_n,
  input  logic              full_in_n,
  output logic              match_out_n,
  output logic              full_out_n,
  output logic              hit_own,
  output logic              free_own,
  output logic              stat_match,
  output logic [ADDR_W-1:0] stat_addr
);

  stat_flags_t       flags_q;
  stat_flags_t       flags_d;
  logic [ADDR_W-1:0] addr_d;
  logic              up_match;
  logic              up_all_full;

  always_comb begin
    flags_d = flags_q;
    addr_d  = stat_addr;
    if (cmp_load) begin
      flags_d.match = loc_match;
      flags_d.full  = loc_full;
      addr_d        = loc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      stat_addr <= '0;
    end else begin
      flags_q   <= flags_d;
      stat_addr <= addr_d;
    end
  end

  always_comb begin
    up_match    = ~match_in_n;
    up_all_full = ~full_in_n;
    match_out_n = ~(up_match | flags_q.match);
    full_out_n  = ~(up_all_full & flags_q.full);
    hit_own     = flags_q.match & ~up_match;
    free_own    = up_all_full & ~flags_q.full;
    stat_match  = flags_q.match;
  end

  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_load |=> ($stable(flags_q) && $stable(stat_addr)));

  // R7
  hit_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_own |-> (!match_out_n && match_in_n));

  // R8
  free_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_own |-> (full_out_n && !full_in_n));

endmodule

// File: rtl/chain_resp_gate.sv
module chain_resp_gate
  import cam_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  logic [2:0] cyc_kind,
  input  logic       selected,
  input  logic       hit_own,
  input  logic       free_own,
  input  logic       stat_match,
  output logic       resp
);

  cyc_kind_e kind;
  logic      allow;

  always_comb begin
    kind = cyc_kind_e'(cyc_kind);
    case (kind)
      CYC_BCAST:   allow = 1'b1;
      CYC_HIT:     allow = hit_own;
      CYC_FREE:    allow = free_own;
      CYC_READ:    allow = stat_match;
      CYC_FREE_RD: allow = 1'b1;
      default:     allow = 1'b0;
    endcase
    resp = cyc_valid & selected & allow;
  end

  // R10
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && (cyc_kind == 3'd1)) |-> hit_own);

  // R11
  free_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && (cyc_kind == 3'd2)) |-> free_own);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid || (cyc_kind > 3'd4)) |-> !resp);

endmodule

// File: rtl/cam_chain_ctrl.sv
module cam_chain_ctrl #(
  parameter int PAGE_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     page_we,
  input  logic [PAGE_W-1:0]        page_wd,
  input  logic                     dsel_we,
  input  logic [PAGE_W-1:0]        dsel_wd,
  input  logic                     cmp_load,
  input  logic                     loc_match,
  input  logic                     loc_full,
  input  logic [ADDR_W-1:0]        loc_addr,
  input  logic                     match_in_n,
  input  logic                     full_in_n,
  output logic                     match_out_n,
  output logic                     full_out_n,
  output logic                     hit_own,
  output logic                     free_own,
  output logic [PAGE_W+ADDR_W-1:0] hit_addr,
  input  logic                     cyc_valid,
  input  logic [2:0]               cyc_kind,
  output logic                     resp
);

  localparam int SYS_W = PAGE_W + ADDR_W;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [PAGE_W-1:0] page_q;
  logic              selected;
  logic              stat_match;
  logic [ADDR_W-1:0] stat_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb rst_i_n = rst_sync_q[1];

  chain_id_regs #(.PAGE_W(PAGE_W)) u_id (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .page_we  (page_we),
    .page_wd  (page_wd),
    .dsel_we  (dsel_we),
    .dsel_wd  (dsel_wd),
    .page_q   (page_q),
    .selected (selected)
  );

  chain_flag_stage #(.ADDR_W(ADDR_W)) u_flag (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .cmp_load    (cmp_load),
    .loc_match   (loc_match),
    .loc_full    (loc_full),
    .loc_addr    (loc_addr),
    .match_in_n  (match_in_n),
    .full_in_n   (full_in_n),
    .match_out_n (match_out_n),
    .full_out_n  (full_out_n),
    .hit_own     (hit_own),
    .free_own    (free_own),
    .stat_match  (stat_match),
    .stat_addr   (stat_addr)
  );

  chain_resp_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .cyc_valid  (cyc_valid),
    .cyc_kind   (cyc_kind),
    .selected   (selected),
    .hit_own    (hit_own),
    .free_own   (free_own),
    .stat_match (stat_match),
    .resp       (resp)
  );

  always_comb begin
    hit_addr = '0;
    if (hit_own) hit_addr = {page_q, stat_addr};
  end

  // R7
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !hit_own |-> (hit_addr == {SYS_W{1'b0}}));

endmodule

// File: tb/sim_cam_chain_ctrl.sv
module sim_cam_chain_ctrl;

  localparam int PW = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          page_we, dsel_we, cmp_load, loc_match, loc_full;
  logic [PW-1:0] page_wd, dsel_wd;
  logic [AW-1:0] loc_addr;
  logic          match_in_n, full_in_n, match_out_n, full_out_n;
  logic          hit_own, free_own, cyc_valid, resp;
  logic [PW+AW-1:0] hit_addr;
  logic [2:0]    cyc_kind;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cam_chain_ctrl #(.PAGE_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .page_we(page_we), .page_wd(page_wd),
    .dsel_we(dsel_we), .dsel_wd(dsel_wd),
    .cmp_load(cmp_load), .loc_match(loc_match), .loc_full(loc_full),
    .loc_addr(loc_addr), .match_in_n(match_in_n), .full_in_n(full_in_n),
    .match_out_n(match_out_n), .full_out_n(full_out_n),
    .hit_own(hit_own), .free_own(free_own), .hit_addr(hit_addr),
    .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .resp(resp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_page(input logic [PW-1:0] v);
    @(negedge clk); page_we = 1'b1; page_wd = v;
    @(negedge clk); page_we = 1'b0;
  endtask

  task automatic wr_dsel(input logic [PW-1:0] v);
    @(negedge clk); dsel_we = 1'b1; dsel_wd = v;
    @(negedge clk); dsel_we = 1'b0;
  endtask

  task automatic capture(input logic m, input logic f, input logic [AW-1:0] a);
    @(negedge clk); cmp_load = 1'b1; loc_match = m; loc_full = f; loc_addr = a;
    @(negedge clk); cmp_load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] page_v;
    rst_n = 1'b0; page_we = 0; dsel_we = 0; cmp_load = 0;
    page_wd = '0; dsel_wd = '0; loc_match = 0; loc_full = 0; loc_addr = '0;
    match_in_n = 1'b1; full_in_n = 1'b1; cyc_valid = 0; cyc_kind = 3'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state, first-device ties for match
    chk("R1 match_out_n", match_out_n, 1);
    chk("R1 full_out_n", full_out_n, 1);
    chk("R1 hit_own", hit_own, 0);
    chk("R1 free_own", free_own, 0);
    chk("R1 hit_addr", hit_addr, 0);
    cyc_valid = 1'b1; cyc_kind = 3'd0; #1;
    chk("R1 R3 broadcast target after reset", resp, 1);
    cyc_kind = 3'd3; #1;
    chk("R1 R12 read blocked without match", resp, 0);
    full_in_n = 1'b0; #1;
    chk("R1 R8 free_own empty device", free_own, 1);
    cyc_valid = 1'b0; full_in_n = 1'b1;

    // R2: page number forms upper address bits
    wr_page(4'hA);
    capture(1'b1, 1'b0, 3'd5);
    #1;
    chk("R2 hit_addr page A addr 5", hit_addr, {4'hA, 3'd5});

    // R4: captured values held without cmp_load
    @(negedge clk); loc_match = 1'b0; loc_addr = 3'd2; loc_full = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 hold match", hit_own, 1);
    chk("R4 hold addr", hit_addr, {4'hA, 3'd5});
    full_in_n = 1'b0; #1;
    chk("R4 hold full", free_own, 1);
    full_in_n = 1'b1;

    // Sweep: target variants x captured flags x chain inputs x cycle codes
    page_v = 4'h5;
    wr_page(page_v);
    for (int sv = 0; sv < 3; sv++) begin
      logic [PW-1:0] dv;
      bit sel;
      dv  = (sv == 0) ? page_v : ((sv == 1) ? 4'hF : 4'h9);
      sel = (dv == page_v) || (dv == 4'hF);
      wr_dsel(dv);
      for (int m = 0; m < 2; m++) begin
        for (int f = 0; f < 2; f++) begin
          capture(m[0], f[0], 3'(m * 3 + f + 1));
          for (int mi = 0; mi < 2; mi++) begin
            for (int fi = 0; fi < 2; fi++) begin
              bit ho, fo;
              @(negedge clk);
              match_in_n = mi[0]; full_in_n = fi[0]; cyc_valid = 1'b0;
              #1;
              ho = (m == 1) && (mi == 1);
              fo = (fi == 0) && (f == 0);
              chk("R5 match_out_n", match_out_n, ((mi == 0) || (m == 1)) ? 0 : 1);
              chk("R6 full_out_n", full_out_n, ((fi == 0) && (f == 1)) ? 0 : 1);
              chk("R7 hit_own", hit_own, ho);
              chk("R7 hit_addr", hit_addr, ho ? int'({page_v, 3'(m * 3 + f + 1)}) : 0);
              chk("R8 free_own", free_own, fo);
              for (int k = 0; k < 8; k++) begin
                int e;
                cyc_kind = 3'(k);
                cyc_valid = 1'b0; #1;
                chk("R13 no cycle", resp, 0);
                cyc_valid = 1'b1; #1;
                case (k)
                  0: e = sel;
                  1: e = sel && ho;
                  2: e = sel && fo;
                  3: e = sel && (m == 1);
                  4: e = sel;
                  default: e = 0;
                endcase
                if (k == 0 || k == 4)      chk("R9 bcast/free-reg read", resp, e);
                else if (k == 1)           chk("R10 hit op", resp, e);
                else if (k == 2)           chk("R11 free op", resp, e);
                else if (k == 3)           chk("R12 read", resp, e);
                else                       chk("R13 undefined code", resp, e);
                if (sv == 2)               chk("R3 unselected silent", resp, 0);
              end
              cyc_valid = 1'b0;
            end
          end
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule